// File: doc/BRIEF.md
# Integer Out-of-Order Issue Queue

This block holds renamed integer instructions until both of their physical source operands hold valid values. It then hands them to two integer execution units without regard to program order. The rename stage presents up to four instructions per cycle. Each one carries two source register tags with busy flags read from the busy-bit table in the same stage, a destination tag, an opcode, an execution class, an instruction tag and a speculation mask.

Inside the queue the slots have no order. Every slot compares the result tags broadcast by the execution units against its own two sources, and it becomes eligible one cycle after a match. In each cycle a selector picks up to two eligible slots, oldest first by instruction tag relative to the oldest in-flight tag, and steers each one to a unit that has the hardware for its class. A slot is released at the clock edge that ends the cycle in which it issues. A flush with a kill mask removes every slot whose speculation mask overlaps the kill mask.

Top module: `int_issue_queue`

## Requirements
- R1: After reset the queue is empty, `iss_valid` is 0 and `ins_stall` is 0.
- R2: Any subset of the four insertion lanes may be valid in a cycle, and each valid lane takes its own slot. Its destination tag, instruction tag, sources and opcode appear unchanged on the issue port that later carries it.
- R3: `ins_stall` is high and no lane is written when the number of valid lanes exceeds the number of free slots counted at the start of the cycle. Slots that issue in that same cycle do not count as free.
- R4: An instruction issues only when both source-ready bits are set. A source-ready bit starts as the inverse of the lane's busy flag.
- R5: A broadcast (`wb_valid[k]` with `wb_tag[k]`) that matches a waiting source sets that source's ready bit at the clock edge, so the earliest issue is the following cycle. A broadcast in the insertion cycle that matches an incoming busy source also makes it ready.
- R6: Class 0 (plain ALU) may go to either unit. Class 1 (shift/branch) goes only to unit 0 and class 2 (multiply/divide) only to unit 1. Class 3 never issues.
- R7: Unit 0 takes the oldest eligible instruction for it, and unit 1 takes the oldest of the rest that it can run. Age is `(itag - head_itag) mod 32`, where a smaller value is older.
- R8: An issued instruction issues exactly once, and its slot is free from the next cycle on. Two units never receive the same slot.
- R9: While `flush` is high, slots whose 4-bit speculation mask ANDed with `kill_mask` is nonzero are removed at the edge. Nothing issues in that cycle, and `ins_stall` is high so nothing is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_itag | input | 5 | Instruction tag of the oldest in-flight instruction (age origin) |
| ins_valid | input | 4 | Per-lane insertion valid |
| ins_src1 | input | 4x6 | Per-lane first source physical tag |
| ins_busy1 | input | 4 | Per-lane busy flag of first source |
| ins_src2 | input | 4x6 | Per-lane second source physical tag |
| ins_busy2 | input | 4 | Per-lane busy flag of second source |
| ins_dst | input | 4x6 | Per-lane destination physical tag |
| ins_itag | input | 4x5 | Per-lane instruction tag |
| ins_opc | input | 4x8 | Per-lane opcode |
| ins_cls | input | 4x2 | Per-lane execution class |
| ins_bmask | input | 4x4 | Per-lane speculation mask |
| ins_stall | output | 1 | Insertion refused this cycle |
| wb_valid | input | 2 | Result broadcast valid per port |
| wb_tag | input | 2x6 | Result broadcast physical tag per port |
| flush | input | 1 | Kill speculative slots this cycle |
| kill_mask | input | 4 | Speculation bits being killed |
| iss_valid | output | 2 | Issue valid per unit |
| iss_itag | output | 2x5 | Issued instruction tag per unit |
| iss_dst | output | 2x6 | Issued destination tag per unit |
| iss_src1 | output | 2x6 | Issued first source tag per unit |
| iss_src2 | output | 2x6 | Issued second source tag per unit |
| iss_opc | output | 2x8 | Issued opcode per unit |

## Verification
The bench builds the queue with its defaults: 16 slots, four insertion lanes and two broadcast ports. With these values, four full-width insertion bursts fill the queue, so the refused-insertion case and the same-cycle-issue free count can be reached in a few cycles. Two broadcast ports let both sources of one instruction wake in the same cycle. A head tag near the top of the 5-bit range exercises age order across the tag wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int PTAG_W = 6;
  parameter int ITAG_W = 5;
  parameter int OPC_W  = 8;
  parameter int BMSK_W = 4;
  parameter int NUNIT  = 2;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_SHB = 2'd1,
    CLS_MDV = 2'd2,
    CLS_RSV = 2'd3
  } uclass_e;

  typedef struct packed {
    logic [PTAG_W-1:0] src1;
    logic              rdy1;
    logic [PTAG_W-1:0] src2;
    logic              rdy2;
    logic [PTAG_W-1:0] dst;
    logic [ITAG_W-1:0] itag;
    logic [OPC_W-1:0]  opc;
    uclass_e           cls;
    logic [BMSK_W-1:0] bmask;
  } uop_t;

  // distance from the oldest in-flight tag, modulo the tag space
  function automatic logic [ITAG_W-1:0] age_of(input logic [ITAG_W-1:0] tag,
                                               input logic [ITAG_W-1:0] head);
    return tag - head;
  endfunction

  function automatic logic is_older(input logic [ITAG_W-1:0] a,
                                    input logic [ITAG_W-1:0] b,
                                    input logic [ITAG_W-1:0] head);
    return age_of(a, head) < age_of(b, head);
  endfunction

  // unit 0 owns the shifter/branch logic, unit 1 the multiplier/divider
  function automatic logic unit_can_run(input int unit, input uclass_e c);
    if (c == CLS_ALU) return 1'b1;
    if (unit == 0)    return c == CLS_SHB;
    if (unit == 1)    return c == CLS_MDV;
    return 1'b0;
  endfunction
endpackage

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int NWB = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  uop_t                         wr_uop,
  input  logic [NWB-1:0]               wb_valid,
  input  logic [NWB-1:0][PTAG_W-1:0]   wb_tag,
  input  logic                         iss_clr,
  input  logic                         flush,
  input  logic [BMSK_W-1:0]            kill_mask,
  output logic                         valid,
  output logic                         ready,
  output logic                         killed,
  output uop_t                         uop
);
  logic hit1, hit2;

  always_comb begin
    hit1 = 1'b0;
    hit2 = 1'b0;
    for (int w = 0; w < NWB; w++) begin
      if (wb_valid[w] && wb_tag[w] == uop.src1) hit1 = 1'b1;
      if (wb_valid[w] && wb_tag[w] == uop.src2) hit2 = 1'b1;
    end
  end

  assign killed = valid && flush && (|(uop.bmask & kill_mask));
  assign ready  = valid && uop.rdy1 && uop.rdy2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      uop   <= '0;
    end else if (wr_en) begin
      valid <= 1'b1;
      uop   <= wr_uop;
    end else if (iss_clr || killed) begin
      valid <= 1'b0;
    end else if (valid) begin
      if (hit1) uop.rdy1 <= 1'b1;
      if (hit2) uop.rdy2 <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int DEPTH = 16,
  parameter int INS_W = 4,
  localparam int LANE_W = (INS_W > 1) ? $clog2(INS_W) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]             free_vec,
  input  logic [INS_W-1:0]             lane_v,
  input  logic                         flush,
  output logic                         stall,
  output logic [DEPTH-1:0]             ent_wr,
  output logic [DEPTH-1:0][LANE_W-1:0] ent_lane
);
  logic [CNT_W-1:0] need, have;
  logic [DEPTH-1:0] avail;
  logic             found;

  always_comb begin
    need  = CNT_W'($countones(lane_v));
    have  = CNT_W'($countones(free_vec));
    stall = flush || (need > have);
    avail    = free_vec;
    ent_wr   = '0;
    ent_lane = '0;
    found    = 1'b0;
    for (int l = 0; l < INS_W; l++) begin
      found = 1'b0;
      if (lane_v[l] && !stall) begin
        for (int e = 0; e < DEPTH; e++) begin
          if (!found && avail[e]) begin
            found       = 1'b1;
            avail[e]    = 1'b0;
            ent_wr[e]   = 1'b1;
            ent_lane[e] = LANE_W'(l);
          end
        end
      end
    end
  end
endmodule

// File: rtl/iq_pick.sv
module iq_pick
  import iq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             cand,
  input  logic [DEPTH-1:0][ITAG_W-1:0] itags,
  input  logic [ITAG_W-1:0]            head,
  output logic                         found,
  output logic [IDX_W-1:0]             idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (cand[e] && (!found || is_older(itags[e], itags[idx], head))) begin
        found = 1'b1;
        idx   = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int INS_W = 4,
  parameter int NWB   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ITAG_W-1:0]               head_itag,
  input  logic [INS_W-1:0]                ins_valid,
  input  logic [INS_W-1:0][PTAG_W-1:0]    ins_src1,
  input  logic [INS_W-1:0]                ins_busy1,
  input  logic [INS_W-1:0][PTAG_W-1:0]    ins_src2,
  input  logic [INS_W-1:0]                ins_busy2,
  input  logic [INS_W-1:0][PTAG_W-1:0]    ins_dst,
  input  logic [INS_W-1:0][ITAG_W-1:0]    ins_itag,
  input  logic [INS_W-1:0][OPC_W-1:0]     ins_opc,
  input  logic [INS_W-1:0][1:0]           ins_cls,
  input  logic [INS_W-1:0][BMSK_W-1:0]    ins_bmask,
  output logic                            ins_stall,
  input  logic [NWB-1:0]                  wb_valid,
  input  logic [NWB-1:0][PTAG_W-1:0]      wb_tag,
  input  logic                            flush,
  input  logic [BMSK_W-1:0]               kill_mask,
  output logic [NUNIT-1:0]                iss_valid,
  output logic [NUNIT-1:0][ITAG_W-1:0]    iss_itag,
  output logic [NUNIT-1:0][PTAG_W-1:0]    iss_dst,
  output logic [NUNIT-1:0][PTAG_W-1:0]    iss_src1,
  output logic [NUNIT-1:0][PTAG_W-1:0]    iss_src2,
  output logic [NUNIT-1:0][OPC_W-1:0]     iss_opc
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LANE_W = (INS_W > 1) ? $clog2(INS_W) : 1;

  function automatic logic bcast_hit(input logic [PTAG_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int w = 0; w < NWB; w++)
      if (wb_valid[w] && wb_tag[w] == t) h = 1'b1;
    return h;
  endfunction

  // named internal events (observed by the checker)
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0]             ent_ready;
  logic [DEPTH-1:0]             ent_killed;
  logic [DEPTH-1:0]             ent_wr;
  logic [DEPTH-1:0]             ent_clr;
  logic [DEPTH-1:0][LANE_W-1:0] ent_lane;
  logic [DEPTH-1:0][ITAG_W-1:0] ent_itag;
  uop_t                         ent_uop [DEPTH];
  uop_t                         lane_uop [INS_W];
  logic                         pick_found [NUNIT];
  logic [IDX_W-1:0]             pick_idx [NUNIT];
  logic [DEPTH-1:0]             taken [NUNIT+1];
  logic [IDX_W-1:0]             sel_idx0, sel_idx1;
  uclass_e                      sel_cls0, sel_cls1;

  // lane payloads with insertion-time readiness (busy table + same-cycle broadcast)
  always_comb begin
    for (int l = 0; l < INS_W; l++) begin
      lane_uop[l].src1  = ins_src1[l];
      lane_uop[l].rdy1  = !ins_busy1[l] || bcast_hit(ins_src1[l]);
      lane_uop[l].src2  = ins_src2[l];
      lane_uop[l].rdy2  = !ins_busy2[l] || bcast_hit(ins_src2[l]);
      lane_uop[l].dst   = ins_dst[l];
      lane_uop[l].itag  = ins_itag[l];
      lane_uop[l].opc   = ins_opc[l];
      lane_uop[l].cls   = uclass_e'(ins_cls[l]);
      lane_uop[l].bmask = ins_bmask[l];
    end
  end

  iq_alloc #(.DEPTH(DEPTH), .INS_W(INS_W)) u_alloc (
    .free_vec (~ent_valid),
    .lane_v   (ins_valid),
    .flush    (flush),
    .stall    (ins_stall),
    .ent_wr   (ent_wr),
    .ent_lane (ent_lane)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    iq_entry #(.NWB(NWB)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ent_wr[e]),
      .wr_uop    (lane_uop[ent_lane[e]]),
      .wb_valid  (wb_valid),
      .wb_tag    (wb_tag),
      .iss_clr   (ent_clr[e]),
      .flush     (flush),
      .kill_mask (kill_mask),
      .valid     (ent_valid[e]),
      .ready     (ent_ready[e]),
      .killed    (ent_killed[e]),
      .uop       (ent_uop[e])
    );
    assign ent_itag[e] = ent_uop[e].itag;
  end

  // unit picks in sequence; each later unit excludes slots already taken
  assign taken[0] = '0;
  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [DEPTH-1:0] cand;
    for (genvar e = 0; e < DEPTH; e++) begin : g_cand
      assign cand[e] = ent_ready[e] && !flush && !taken[u][e] &&
                       unit_can_run(u, ent_uop[e].cls);
    end
    iq_pick #(.DEPTH(DEPTH)) u_pick (
      .cand  (cand),
      .itags (ent_itag),
      .head  (head_itag),
      .found (pick_found[u]),
      .idx   (pick_idx[u])
    );
    assign taken[u+1] = taken[u] |
                        (pick_found[u] ? (DEPTH'(1) << pick_idx[u]) : '0);
    assign iss_valid[u] = pick_found[u];
    assign iss_itag[u]  = ent_uop[pick_idx[u]].itag;
    assign iss_dst[u]   = ent_uop[pick_idx[u]].dst;
    assign iss_src1[u]  = ent_uop[pick_idx[u]].src1;
    assign iss_src2[u]  = ent_uop[pick_idx[u]].src2;
    assign iss_opc[u]   = ent_uop[pick_idx[u]].opc;
  end

  assign ent_clr = taken[NUNIT];

  assign sel_idx0 = pick_idx[0];
  assign sel_idx1 = pick_idx[1];
  assign sel_cls0 = ent_uop[pick_idx[0]].cls;
  assign sel_cls1 = ent_uop[pick_idx[1]].cls;
endmodule

// File: rtl/iq_checker.sv
module iq_checker
  import iq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int INS_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INS_W-1:0]  ins_valid,
  input logic              ins_stall,
  input logic              flush,
  input logic [NUNIT-1:0]  iss_valid,
  input logic [DEPTH-1:0]  ent_valid,
  input logic [IDX_W-1:0]  sel_idx0,
  input logic [IDX_W-1:0]  sel_idx1,
  input uclass_e           sel_cls0,
  input uclass_e           sel_cls1
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_stall |-> ($countones(ent_valid) + $countones(ins_valid) <= DEPTH));

  p_unit0_steer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> (sel_cls0 == CLS_ALU || sel_cls0 == CLS_SHB));

  p_unit1_steer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (sel_cls1 == CLS_ALU || sel_cls1 == CLS_MDV));

  p_distinct_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid[0] && iss_valid[1]) |-> (sel_idx0 != sel_idx1));

  p_slot_freed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |=> !ent_valid[$past(sel_idx0)]);

  p_issued_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> ent_valid[sel_idx1]);

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_valid == '0 && ins_stall));
endmodule

bind int_issue_queue iq_checker #(.DEPTH(DEPTH), .INS_W(INS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_stall (ins_stall),
  .flush     (flush),
  .iss_valid (iss_valid),
  .ent_valid (ent_valid),
  .sel_idx0  (sel_idx0),
  .sel_idx1  (sel_idx1),
  .sel_cls0  (sel_cls0),
  .sel_cls1  (sel_cls1)
);

// File: tb/int_issue_queue_test.sv
`timescale 1ns/1ps
module int_issue_queue_test;
  localparam int ALU = 0, SHB = 1, MDV = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0]      head_itag;
  logic [3:0]      ins_valid;
  logic [3:0][5:0] ins_src1, ins_src2, ins_dst;
  logic [3:0]      ins_busy1, ins_busy2;
  logic [3:0][4:0] ins_itag;
  logic [3:0][7:0] ins_opc;
  logic [3:0][1:0] ins_cls;
  logic [3:0][3:0] ins_bmask;
  logic            ins_stall;
  logic [1:0]      wb_valid;
  logic [1:0][5:0] wb_tag;
  logic            flush;
  logic [3:0]      kill_mask;
  logic [1:0]      iss_valid;
  logic [1:0][4:0] iss_itag;
  logic [1:0][5:0] iss_dst, iss_src1, iss_src2;
  logic [1:0][7:0] iss_opc;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  typedef struct { int unit; int itag; } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  always #2.5 clk = ~clk;

  int_issue_queue uut (
    .clk(clk), .rst_n(rst_n), .head_itag(head_itag),
    .ins_valid(ins_valid), .ins_src1(ins_src1), .ins_busy1(ins_busy1),
    .ins_src2(ins_src2), .ins_busy2(ins_busy2), .ins_dst(ins_dst),
    .ins_itag(ins_itag), .ins_opc(ins_opc), .ins_cls(ins_cls),
    .ins_bmask(ins_bmask), .ins_stall(ins_stall),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .flush(flush), .kill_mask(kill_mask),
    .iss_valid(iss_valid), .iss_itag(iss_itag), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_opc(iss_opc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    ins_valid = '0;
    wb_valid  = '0;
    flush     = 1'b0;
  endtask

  task automatic set_lane(input int l, input int tg, input int s1, input bit b1,
                          input int s2, input bit b2, input int cls, input int bm);
    ins_valid[l] = 1'b1;
    ins_itag[l]  = 5'(tg);
    ins_src1[l]  = 6'(s1);
    ins_busy1[l] = b1;
    ins_src2[l]  = 6'(s2);
    ins_busy2[l] = b2;
    ins_dst[l]   = 6'(32 + tg);
    ins_opc[l]   = 8'(tg);
    ins_cls[l]   = 2'(cls);
    ins_bmask[l] = 4'(bm);
  endtask

  task automatic expect_iss(input int u, input int tg);
    exp_t e;
    e.unit = u;
    e.itag = tg;
    exp_q.push_back(e);
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) tick();
    chk(exp_q.size() == 0, req, "expected issues still pending", exp_q.size(), 0);
  endtask

  // monitor: compares every issue against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int u = 0; u < 2; u++) begin
        if (iss_valid[u]) begin
          n_checks++;
          if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R8 unexpected issue on unit %0d: actual itag %0d expected none",
                     u, iss_itag[u]);
          end else begin
            mon_e = exp_q.pop_front();
            if (mon_e.unit != u || int'(iss_itag[u]) != mon_e.itag) begin
              n_err++;
              $display("FAIL R7 issue order: actual unit %0d itag %0d expected unit %0d itag %0d",
                       u, iss_itag[u], mon_e.unit, mon_e.itag);
            end else if (int'(iss_dst[u]) != 32 + mon_e.itag ||
                         int'(iss_opc[u]) != mon_e.itag) begin
              n_err++;
              $display("FAIL R2 payload of itag %0d: actual dst %0d expected %0d",
                       mon_e.itag, iss_dst[u], 32 + mon_e.itag);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    head_itag = '0;
    kill_mask = '0;
    ins_src1 = '0; ins_src2 = '0; ins_dst = '0; ins_busy1 = '0; ins_busy2 = '0;
    ins_itag = '0; ins_opc = '0; ins_cls = '0; ins_bmask = '0; wb_tag = '0;
    idle_inputs();
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_valid == 2'b00, "R1", "issue after reset", iss_valid, 0);
    chk(ins_stall == 1'b0, "R1", "stall after reset", ins_stall, 0);

    // R2 / R7: four ready ALU ops in scrambled lane order
    tick();
    set_lane(0, 3, 1, 0, 2, 0, ALU, 0);
    set_lane(1, 1, 1, 0, 2, 0, ALU, 0);
    set_lane(2, 2, 1, 0, 2, 0, ALU, 0);
    set_lane(3, 0, 1, 0, 2, 0, ALU, 0);
    expect_iss(0, 0); expect_iss(1, 1); expect_iss(0, 2); expect_iss(1, 3);
    tick();
    idle_inputs();
    @(negedge clk);
    chk(iss_valid == 2'b11, "R7", "dual issue", iss_valid, 3);
    drain(3, "R2");

    // R4 / R5: both sources busy, woken by two ports at once
    tick();
    set_lane(0, 5, 10, 1, 11, 1, ALU, 0);
    tick();
    idle_inputs();
    @(negedge clk);
    chk(iss_valid == 2'b00, "R4", "issue with busy sources", iss_valid, 0);
    tick();
    @(negedge clk);
    chk(iss_valid == 2'b00, "R4", "issue with busy sources", iss_valid, 0);
    tick();
    wb_valid = 2'b11; wb_tag[0] = 6'd10; wb_tag[1] = 6'd11;
    @(negedge clk);
    chk(iss_valid == 2'b00, "R5", "issue in broadcast cycle", iss_valid, 0);
    tick();
    wb_valid = '0;
    expect_iss(0, 5);
    @(negedge clk);
    chk(iss_valid[0] == 1'b1, "R5", "issue cycle after broadcast", iss_valid[0], 1);
    drain(2, "R5");

    // R5: broadcast in the insertion cycle
    tick();
    set_lane(0, 6, 12, 1, 13, 0, ALU, 0);
    wb_valid = 2'b10; wb_tag[1] = 6'd12;
    expect_iss(0, 6);
    tick();
    idle_inputs();
    @(negedge clk);
    chk(iss_valid[0] == 1'b1, "R5", "insert-time wakeup", iss_valid[0], 1);
    drain(2, "R5");

    // R6: class steering
    tick();
    set_lane(0, 7, 1, 0, 2, 0, MDV, 0);
    set_lane(1, 8, 1, 0, 2, 0, SHB, 0);
    set_lane(2, 9, 1, 0, 2, 0, MDV, 0);
    expect_iss(0, 8); expect_iss(1, 7); expect_iss(1, 9);
    tick();
    idle_inputs();
    @(negedge clk);
    chk(iss_valid == 2'b11, "R6", "split by class", iss_valid, 3);
    tick();
    @(negedge clk);
    chk(iss_valid == 2'b10, "R6", "muldiv only on unit 1", iss_valid, 2);
    drain(2, "R6");
    tick();
    set_lane(0, 10, 1, 0, 2, 0, SHB, 0);
    set_lane(1, 11, 1, 0, 2, 0, SHB, 0);
    expect_iss(0, 10); expect_iss(0, 11);
    tick();
    idle_inputs();
    @(negedge clk);
    chk(iss_valid == 2'b01, "R6", "shift only on unit 0", iss_valid, 1);
    drain(3, "R6");

    // R7: age across tag wrap
    head_itag = 5'd30;
    tick();
    set_lane(0, 1, 1, 0, 2, 0, ALU, 0);
    set_lane(1, 31, 1, 0, 2, 0, ALU, 0);
    set_lane(2, 30, 1, 0, 2, 0, ALU, 0);
    set_lane(3, 0, 1, 0, 2, 0, ALU, 0);
    expect_iss(0, 30); expect_iss(1, 31); expect_iss(0, 0); expect_iss(1, 1);
    tick();
    idle_inputs();
    drain(3, "R7");
    head_itag = 5'd0;

    // R3 / R8: fill all 16 slots, then free and refill
    for (int c = 0; c < 4; c++) begin
      tick();
      for (int l = 0; l < 4; l++) set_lane(l, 4 * c + l, 40, 1, 1, 0, ALU, 0);
    end
    tick();
    idle_inputs();
    set_lane(0, 16, 1, 0, 2, 0, ALU, 0);
    @(negedge clk);
    chk(ins_stall == 1'b1, "R3", "stall when full", ins_stall, 1);
    tick();
    idle_inputs();
    wb_valid = 2'b01; wb_tag[0] = 6'd40;
    for (int k = 0; k < 8; k++) begin
      expect_iss(0, 2 * k);
      expect_iss(1, 2 * k + 1);
    end
    expect_iss(0, 20); expect_iss(1, 21);
    tick();
    wb_valid = '0;
    set_lane(0, 20, 1, 0, 2, 0, ALU, 0);
    set_lane(1, 21, 1, 0, 2, 0, ALU, 0);
    @(negedge clk);
    chk(ins_stall == 1'b1, "R3", "same-cycle issue not counted free", ins_stall, 1);
    chk(iss_valid == 2'b11, "R8", "dual issue from full queue", iss_valid, 3);
    tick();
    @(negedge clk);
    chk(ins_stall == 1'b0, "R8", "slots free after issue", ins_stall, 0);
    tick();
    idle_inputs();
    drain(10, "R8");

    // R9: flush removes masked slots, blocks issue and insertion
    tick();
    set_lane(0, 1, 50, 1, 3, 0, ALU, 1);
    set_lane(1, 2, 50, 1, 3, 0, ALU, 2);
    set_lane(2, 3, 50, 1, 3, 0, ALU, 0);
    tick();
    idle_inputs();
    set_lane(0, 5, 4, 0, 4, 0, ALU, 0);
    tick();
    idle_inputs();
    flush = 1'b1; kill_mask = 4'b0001;
    set_lane(0, 4, 4, 0, 4, 0, ALU, 0);
    @(negedge clk);
    chk(ins_stall == 1'b1, "R9", "stall during flush", ins_stall, 1);
    chk(iss_valid == 2'b00, "R9", "no issue during flush", iss_valid, 0);
    tick();
    idle_inputs();
    kill_mask = '0;
    wb_valid = 2'b01; wb_tag[0] = 6'd50;
    expect_iss(0, 5);
    @(negedge clk);
    chk(iss_valid == 2'b01, "R9", "survivor issues after flush", iss_valid, 1);
    tick();
    wb_valid = '0;
    expect_iss(0, 2); expect_iss(1, 3);
    drain(5, "R9");

    finish_run();
  end
endmodule